// File: doc/BRIEF.md
# Hotplug Event Interrupt Aggregator

This block gathers the hotplug events of a row of slots, plus a command-completion flag, into one interrupt locator word and a single interrupt request. Each slot keeps a small register of sticky event flags, which hardware event pulses set and a write of ones clears. Each slot also has a mask register that hides some of those flags from the interrupt. A global control register holds the master interrupt mask, the command-interrupt mask, two error-signalling masks that this block only stores, and two sticky detection flags.

The locator word shows which sources want service. Bit 0 is the command source. Bit k, for k from 1 to the slot count, is slot k-1. The interrupt level is the OR of the locator, gated by the master mask. When message mode is off, the level drives a wired interrupt. When message mode is on, the wired line stays low and the block emits a one-cycle message request on every change of level, whether the level rises or falls.

Top module: `hp_irq_aggregator`

## Requirements
- R1: After reset, every slot event register reads 0, every slot mask register holds 0x7F, the control word reads 0x0000000F, and the locator, level, wired interrupt and message request are all 0.
- R2: An event pulse on a flag of slot i (presence bit 0, isolated fault bit 1, button bit 2, latch-lever bit 3, connected fault bit 4) latches that flag at the next edge. From then on, locator bit i+1 reads 1 for as long as the slot's latched flags ANDed with the inverse of mask bits 4:0 are nonzero.
- R3: A clear write to slot i clears each latched flag whose data bit is 1 and leaves the others unchanged. If an event pulse and a clear hit the same flag in the same cycle, the flag stays set.
- R4: A mask write to slot i loads all 7 bits. Mask bits 5 and 6 have no effect on the locator.
- R5: Locator bit 0 reads 1 exactly when the command-detected flag (control bit 16) is 1 and the command-interrupt mask (control bit 2) is 0.
- R6: A command-done pulse sets control bit 16, and an arbiter-detected pulse sets control bit 17. A control write with the matching clear bit set clears each flag, and a pulse in the same cycle wins over the clear. Bit 17 never affects the locator.
- R7: The interrupt level is 1 exactly when control bit 0 is 0 and the locator is nonzero. Locator bits above the slot count always read 0.
- R8: When message mode is off, the wired interrupt equals the level. When message mode is on, the wired interrupt is 0.
- R9: When message mode is on, a change of level, either up or down, produces a message request of exactly one cycle in the cycle after the change.
- R10: A control write loads bits 3:0 from its data. All control-word bits other than 0 to 3, 16 and 17 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_evt_i | input | NUM_SLOTS*5 | Event pulses; slot i uses bits [5i+4:5i] |
| evt_clr_we_i | input | NUM_SLOTS | Per-slot clear strobe |
| evt_clr_data_i | input | 5 | Ones select the flags to clear |
| mask_we_i | input | NUM_SLOTS | Per-slot mask write strobe |
| mask_data_i | input | 7 | Mask value to load |
| cmd_done_i | input | 1 | Command-completion pulse |
| arb_det_i | input | 1 | Arbiter error pulse |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_mask_i | input | 4 | New values of control bits 3:0 |
| ctl_clr_i | input | 2 | Clear bits for control bits 16 and 17 |
| msg_en_i | input | 1 | Message mode enable |
| locator_o | output | 32 | Interrupt locator word |
| ctl_o | output | 32 | Control word readback |
| irq_level_o | output | 1 | Computed interrupt level |
| irq_o | output | 1 | Wired interrupt |
| msg_req_o | output | 1 | One-cycle message request |

## Verification
Every stimulus is applied to the registers at one edge. The locator, control word, level and wired interrupt are combinational from those registers, so they are due just after that same edge. The message request passes through one more register and is due one edge later. The driver applies inputs at the falling edge. After each rising edge, it pushes the values that a reference model built from the requirements expects at that edge. The monitor compares the outputs against them 1 ns after that rising edge, before any input moves. Because the model carries the previous level across edges, the one-cycle delay of the message request is checked in the cycle it falls due.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int EVT_W  = 5;
  localparam int MASK_W = 7;
  localparam int LOC_W  = 32;
  localparam int GMASK_W = 4;
  localparam logic [MASK_W-1:0] MASK_RESET = '1;
  localparam logic [GMASK_W-1:0] GMASK_RESET = '1;
  localparam int GM_INT_OFF = 0;
  localparam int GM_CMD_OFF = 2;
  localparam int CMD_FLAG_BIT = 16;
  localparam int ARB_FLAG_BIT = 17;
endpackage

// File: rtl/hpa_slot_reg.sv
module hpa_slot_reg
  import hpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              clr_we_i,
  input  logic [EVT_W-1:0]  clr_data_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_data_i,
  output logic              active_o
);
  logic [EVT_W-1:0]  flags_q, flags_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [EVT_W-1:0]  clr_sel;

  always_comb begin
    clr_sel = clr_we_i ? clr_data_i : '0;
    flags_d = (flags_q & ~clr_sel) | evt_i;
    mask_d  = mask_we_i ? mask_data_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= MASK_RESET;
    end else begin
      flags_q <= flags_d;
      if (mask_we_i) mask_q <= mask_d;
    end
  end

  assign active_o = |(flags_q & ~mask_q[EVT_W-1:0]);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && |(clr_data_i & ~evt_i)) |=>
      ((flags_q & $past(clr_data_i & ~evt_i)) == '0));

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_q == $past(mask_data_i)));
endmodule

// File: rtl/hpa_ctrl_reg.sv
module hpa_ctrl_reg
  import hpa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_done_i,
  input  logic               arb_det_i,
  input  logic               we_i,
  input  logic [GMASK_W-1:0] mask_i,
  input  logic [1:0]         clr_i,
  output logic [LOC_W-1:0]   ctl_o,
  output logic               cmd_src_o,
  output logic               int_off_o
);
  logic [GMASK_W-1:0] gmask_q, gmask_d;
  logic cmd_q, cmd_d, arb_q, arb_d;
  logic [1:0] clr_sel;

  always_comb begin
    clr_sel = we_i ? clr_i : 2'b00;
    gmask_d = we_i ? mask_i : gmask_q;
    cmd_d   = (cmd_q & ~clr_sel[0]) | cmd_done_i;
    arb_d   = (arb_q & ~clr_sel[1]) | arb_det_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q <= GMASK_RESET;
      cmd_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      if (we_i) gmask_q <= gmask_d;
      cmd_q <= cmd_d;
      arb_q <= arb_d;
    end
  end

  always_comb begin
    ctl_o = '0;
    ctl_o[GMASK_W-1:0]  = gmask_q;
    ctl_o[CMD_FLAG_BIT] = cmd_q;
    ctl_o[ARB_FLAG_BIT] = arb_q;
  end

  assign cmd_src_o = cmd_q & ~gmask_q[GM_CMD_OFF];
  assign int_off_o = gmask_q[GM_INT_OFF];

  assert_cmd_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && clr_i[0] && !cmd_done_i) |=> !ctl_o[CMD_FLAG_BIT]);

  assert_cmd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_i |=> ctl_o[CMD_FLAG_BIT]);

  assert_ctl_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ctl_o[GMASK_W-1:0] == $past(mask_i)));
endmodule

// File: rtl/hpa_notify.sv
module hpa_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic msg_en_i,
  output logic irq_o,
  output logic msg_req_o
);
  logic last_q, last_d;
  logic req_q, req_d;

  always_comb begin
    last_d = level_i;
    req_d  = msg_en_i && (level_i != last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      req_q  <= req_d;
    end
  end

  assign irq_o     = msg_en_i ? 1'b0 : level_i;
  assign msg_req_o = req_q;

  assert_req_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(level_i) && msg_en_i) |=> msg_req_o);

  assert_req_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(level_i) && msg_en_i) |=> msg_req_o);

  assert_req_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req_o |-> $past(msg_en_i));
endmodule

// File: rtl/hp_irq_aggregator.sv
module hp_irq_aggregator
  import hpa_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS*EVT_W-1:0] slot_evt_i,
  input  logic [NUM_SLOTS-1:0]       evt_clr_we_i,
  input  logic [EVT_W-1:0]           evt_clr_data_i,
  input  logic [NUM_SLOTS-1:0]       mask_we_i,
  input  logic [MASK_W-1:0]          mask_data_i,
  input  logic                       cmd_done_i,
  input  logic                       arb_det_i,
  input  logic                       ctl_we_i,
  input  logic [GMASK_W-1:0]         ctl_mask_i,
  input  logic [1:0]                 ctl_clr_i,
  input  logic                       msg_en_i,
  output logic [LOC_W-1:0]           locator_o,
  output logic [LOC_W-1:0]           ctl_o,
  output logic                       irq_level_o,
  output logic                       irq_o,
  output logic                       msg_req_o
);
  localparam int TOP_BIT = NUM_SLOTS + 1;

  logic [NUM_SLOTS-1:0] slot_active;
  logic cmd_src, int_off;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hpa_slot_reg u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (slot_evt_i[s*EVT_W +: EVT_W]),
      .clr_we_i   (evt_clr_we_i[s]),
      .clr_data_i (evt_clr_data_i),
      .mask_we_i  (mask_we_i[s]),
      .mask_data_i(mask_data_i),
      .active_o   (slot_active[s])
    );
  end

  hpa_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_done_i(cmd_done_i),
    .arb_det_i (arb_det_i),
    .we_i      (ctl_we_i),
    .mask_i    (ctl_mask_i),
    .clr_i     (ctl_clr_i),
    .ctl_o     (ctl_o),
    .cmd_src_o (cmd_src),
    .int_off_o (int_off)
  );

  for (genvar k = 0; k < LOC_W; k++) begin : g_loc
    if (k == 0) begin : g_cmd
      assign locator_o[k] = cmd_src;
    end else if (k <= NUM_SLOTS) begin : g_sl
      assign locator_o[k] = slot_active[k-1];
    end else begin : g_zero
      assign locator_o[k] = 1'b0;
    end
  end

  assign irq_level_o = !int_off && (|locator_o);

  hpa_notify u_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (irq_level_o),
    .msg_en_i (msg_en_i),
    .irq_o    (irq_o),
    .msg_req_o(msg_req_o)
  );

  assert_loc_high_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locator_o >> TOP_BIT) == '0);

  assert_level_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o |-> (!ctl_o[GM_INT_OFF] && locator_o != '0));

  assert_wired_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_en_i |-> !irq_o);

  assert_cmd_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locator_o[0] |-> (ctl_o[CMD_FLAG_BIT] && !ctl_o[GM_CMD_OFF]));
endmodule

// File: tb/test_hp_irq_aggregator.sv
`timescale 1ns/1ps
module test_hp_irq_aggregator;
  localparam int NS = 4;
  localparam time CYC = 10ns;

  logic clk = 0, rst_n = 0;
  logic [NS*5-1:0] slot_evt;
  logic [NS-1:0] clr_we, mask_we;
  logic [4:0] clr_data;
  logic [6:0] mask_data;
  logic cmd_done, arb_det, ctl_we, msg_en;
  logic [3:0] ctl_mask;
  logic [1:0] ctl_clr;
  logic [31:0] locator, ctl;
  logic level, irq, msg_req;

  always #(CYC/2) clk = ~clk;

  hp_irq_aggregator #(.NUM_SLOTS(NS)) i_hp_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .slot_evt_i(slot_evt), .evt_clr_we_i(clr_we),
    .evt_clr_data_i(clr_data), .mask_we_i(mask_we), .mask_data_i(mask_data),
    .cmd_done_i(cmd_done), .arb_det_i(arb_det), .ctl_we_i(ctl_we),
    .ctl_mask_i(ctl_mask), .ctl_clr_i(ctl_clr), .msg_en_i(msg_en),
    .locator_o(locator), .ctl_o(ctl), .irq_level_o(level), .irq_o(irq),
    .msg_req_o(msg_req));

  typedef struct {
    logic [31:0] loc; logic [31:0] ctl; logic lvl; logic irq; logic req;
    string tag;
  } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;

  // reference model
  logic [4:0] m_flag [NS];
  logic [6:0] m_mask [NS];
  logic [3:0] m_gm;
  logic m_cmd, m_arb, m_last, m_req;

  function automatic logic [31:0] m_loc();
    logic [31:0] l = '0;
    l[0] = m_cmd & ~m_gm[2];
    for (int s = 0; s < NS; s++) l[s+1] = |(m_flag[s] & ~m_mask[s][4:0]);
    return l;
  endfunction

  function automatic logic m_lvl();
    return !m_gm[0] && (m_loc() != 0);
  endfunction

  function automatic logic [31:0] m_ctl();
    logic [31:0] c = '0;
    c[3:0] = m_gm; c[16] = m_cmd; c[17] = m_arb;
    return c;
  endfunction

  task automatic idle_inputs();
    slot_evt = '0; clr_we = '0; mask_we = '0; clr_data = '0; mask_data = '0;
    cmd_done = 0; arb_det = 0; ctl_we = 0; ctl_mask = '0; ctl_clr = '0;
  endtask

  // one clock with the current inputs; push the expected outputs
  task automatic cyc(input string tag);
    exp_t e;
    logic lv_old;
    lv_old = m_lvl();
    @(posedge clk);
    m_req  = msg_en && (lv_old != m_last);
    m_last = lv_old;
    for (int s = 0; s < NS; s++) begin
      m_flag[s] = (m_flag[s] & ~(clr_we[s] ? clr_data : 5'd0)) | slot_evt[s*5 +: 5];
      if (mask_we[s]) m_mask[s] = mask_data;
    end
    m_cmd = (m_cmd & ~(ctl_we & ctl_clr[0])) | cmd_done;
    m_arb = (m_arb & ~(ctl_we & ctl_clr[1])) | arb_det;
    if (ctl_we) m_gm = ctl_mask;
    e.loc = m_loc(); e.ctl = m_ctl(); e.lvl = m_lvl();
    e.irq = msg_en ? 1'b0 : e.lvl; e.req = m_req; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (locator !== e.loc || ctl !== e.ctl || level !== e.lvl ||
          irq !== e.irq || msg_req !== e.req) begin
        n_bad++;
        $display("FAIL %s: got loc=%h ctl=%h lvl=%b irq=%b req=%b exp loc=%h ctl=%h lvl=%b irq=%b req=%b",
                 e.tag, locator, ctl, level, irq, msg_req,
                 e.loc, e.ctl, e.lvl, e.irq, e.req);
      end
    end
  end

  initial begin
    #(CYC*5000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    msg_en = 0;
    for (int s = 0; s < NS; s++) begin m_flag[s] = '0; m_mask[s] = 7'h7F; end
    m_gm = 4'hF; m_cmd = 0; m_arb = 0; m_last = 0; m_req = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, checked directly before release
    n_cmp++;
    if (locator !== 0 || ctl !== 32'hF || level !== 0 || irq !== 0 || msg_req !== 0) begin
      n_bad++;
      $display("FAIL R1: got loc=%h ctl=%h exp loc=0 ctl=0000000f", locator, ctl);
    end
    rst_n = 1;
    cyc("R1 idle after reset");
    // R2: event hidden by reset mask
    slot_evt[0] = 1'b1; cyc("R2 masked presence");
    mask_data = 7'h00; mask_we[0] = 1; cyc("R2 unmask slot0");
    // R7: master mask still on, then enable
    ctl_we = 1; ctl_mask = 4'h0; cyc("R7 level enable");
    cyc("R8 wired follows level");
    // R3: clear with ones
    clr_we[0] = 1; clr_data = 5'h01; cyc("R3 w1c presence");
    // R4: SERR-only mask bits ignored
    mask_we[2] = 1; mask_data = 7'h60; cyc("R4 mask 0x60 slot2");
    slot_evt[2*5+3] = 1; cyc("R4 lever event shows");
    // R3: set beats clear
    slot_evt[2*5+2] = 1; clr_we[2] = 1; clr_data = 5'h0C; cyc("R3 set wins button");
    clr_we[2] = 1; clr_data = 5'h1F; cyc("R3 clear all slot2");
    // R2 masked by low mask bits
    mask_we[3] = 1; mask_data = 7'h1F; slot_evt[3*5+4] = 1; cyc("R2 fault masked slot3");
    mask_we[3] = 1; mask_data = 7'h0F; cyc("R2 unmask fault slot3");
    clr_we[3] = 1; clr_data = 5'h10; cyc("R3 clear slot3");
    // R5 / R6 command source
    cmd_done = 1; cyc("R5 cmd detected");
    ctl_we = 1; ctl_mask = 4'h4; cyc("R5 cmd masked");
    ctl_we = 1; ctl_mask = 4'h0; cmd_done = 1; ctl_clr = 2'b01; cyc("R6 pulse beats clear");
    ctl_we = 1; ctl_mask = 4'h0; ctl_clr = 2'b01; cyc("R6 w1c cmd");
    arb_det = 1; cyc("R6 arb no locator");
    ctl_we = 1; ctl_mask = 4'h0; ctl_clr = 2'b10; cyc("R6 w1c arb");
    // R7: all slots, high bits zero
    slot_evt = '1; mask_we = '1; mask_data = 7'h00; cyc("R7 all slots");
    ctl_we = 1; ctl_mask = 4'hF; ctl_clr = 2'b11; cyc("R10 readback");
    // R9 message mode
    msg_en = 1; ctl_we = 1; ctl_mask = 4'h0; cyc("R9 level rises");
    cyc("R9 pulse after rise");
    cyc("R9 single cycle");
    clr_we = '1; clr_data = 5'h1F; cyc("R9 level falls");
    cyc("R9 pulse after fall");
    cyc("R9 quiet");
    msg_en = 0; cmd_done = 1; cyc("R8 wired mode again");
    cyc("R8 no request when off");
    @(posedge clk); #2;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule